// File: doc/BRIEF.md
# Write-Once Saturating Down-Counter

This block holds a 17-bit count in a slot that can be programmed only once. A host writes the starting value with a load strobe and its data word. After that first load the slot is locked, and the value can change only through a separate decrement strobe. Each decrement takes one off the count. When the count reaches zero it stays there. It never wraps round.

Every command cycle produces a 2-bit status code. The code appears on the clock cycle that follows the command, along with a one-cycle valid flag. It tells the host whether the command took effect, and if not, why it was refused. The current count and a programmed flag can be read at any time. A typical use is as a usage or credit budget: it is written once at provisioning time and then consumed one step per use.

Top module: `otp_dec_counter`

## Requirements
- R1: While reset is asserted and after it is released, `count` reads 0x1FFFF, `programmed` is 0 and `status_vld` is 0.
- R2: A load strobe while unprogrammed stores `ld_data` into `count`, sets `programmed` to 1 and reports status 2'b00 (ok) on the next cycle.
- R3: A load strobe once programmed leaves `count` unchanged and reports status 2'b01 (already written) on the next cycle.
- R4: A decrement strobe without a load strobe, while programmed and with `count` non-zero, lowers `count` by exactly one on the next cycle and reports status 2'b00.
- R5: A decrement strobe without a load strobe, while programmed and with `count` equal to zero, leaves `count` at zero and reports status 2'b10 (at zero).
- R6: A decrement strobe without a load strobe while unprogrammed leaves `count` unchanged and reports status 2'b11 (not programmed).
- R7: When load and decrement strobes fall in the same cycle, only the load is handled: its status (R2 or R3) is reported and no decrement is applied.
- R8: `status_vld` is 1 exactly in the cycle after a cycle with at least one strobe, and 0 otherwise.
- R9: Once set, `programmed` stays 1 until reset.
- R10: In a cycle with no strobe, `count` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | Load command strobe |
| ld_data | input | 17 | Initial count offered with the load |
| dec_stb | input | 1 | Decrement command strobe |
| count | output | 17 | Current count |
| programmed | output | 1 | High once the slot has been loaded |
| status_vld | output | 1 | Status is valid this cycle |
| status | output | 2 | Result code of the previous command cycle |

## Verification
The load path and the decrement path can both be requested in the same cycle. The bench provokes this by raising both strobes together in three states: unprogrammed, programmed with a non-zero count, and programmed at zero. In each case the reference model requires the load outcome to be reported, and requires the count to be exactly what the load alone would leave. A decrement that slipped through would show up as a count one lower, or as the wrong status code.

// File: rtl/otp_dec_counter.sv
module otp_dec_counter #(
  parameter int WIDTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             dec_stb,
  output logic [WIDTH-1:0] count,
  output logic             programmed,
  output logic             status_vld,
  output logic [1:0]       status
);

  localparam logic [WIDTH-1:0] FULL = '1;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [1:0] ST_OK     = 2'b00;
  localparam logic [1:0] ST_LOCKED = 2'b01;
  localparam logic [1:0] ST_ZERO   = 2'b10;
  localparam logic [1:0] ST_UNPROG = 2'b11;

  logic [WIDTH-1:0] cnt_q;
  logic             prog_q;
  logic             vld_q;
  logic [1:0]       st_q;
  logic [1:0]       st_d;

  wire at_zero = (cnt_q == '0);
  wire any_cmd = ld_stb | dec_stb;
  wire load_ok = ld_stb & ~prog_q;
  wire dec_ok  = dec_stb & ~ld_stb & prog_q & ~at_zero;

  always_comb begin
    if (ld_stb)       st_d = prog_q ? ST_LOCKED : ST_OK;
    else if (!prog_q) st_d = ST_UNPROG;
    else if (at_zero) st_d = ST_ZERO;
    else              st_d = ST_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= FULL;
      prog_q <= 1'b0;
      vld_q  <= 1'b0;
      st_q   <= ST_OK;
    end else begin
      vld_q <= any_cmd;
      st_q  <= any_cmd ? st_d : ST_OK;
      if (load_ok) begin
        cnt_q  <= ld_data;
        prog_q <= 1'b1;
      end else if (dec_ok) begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign count      = cnt_q;
  assign programmed = prog_q;
  assign status_vld = vld_q;
  assign status     = st_q;

  a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb && !programmed |=> programmed && count == $past(ld_data) && status == ST_OK);

  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb && programmed |=> $stable(count) && status == ST_LOCKED);

  a_r4_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb && !ld_stb && programmed && count != '0 |=> count == $past(count) - ONE && status == ST_OK);

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb && !ld_stb && programmed && count == '0 |=> count == '0 && status == ST_ZERO);

  a_r6_unprog_dec: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb && !ld_stb && !programmed |=> $stable(count) && !programmed && status == ST_UNPROG);

  a_r8_vld_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb || dec_stb) |=> status_vld);

  a_r8_vld_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_stb || dec_stb) |=> !status_vld);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    programmed |=> programmed);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_stb && !dec_stb |=> $stable(count));

endmodule

// File: tb/otp_dec_counter_tb.sv
`timescale 1ns/1ps
module otp_dec_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_stb = 1'b0;
  logic [16:0] ld_data = '0;
  logic        dec_stb = 1'b0;
  logic [16:0] count;
  logic        programmed;
  logic        status_vld;
  logic [1:0]  status;

  otp_dec_counter u_dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_data(ld_data),
    .dec_stb(dec_stb), .count(count), .programmed(programmed),
    .status_vld(status_vld), .status(status)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_cnt;
  bit m_prog;
  bit m_vld;
  int m_st;
  string tag;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "count", int'(count), m_cnt);
    chk(tag, "programmed", int'(programmed), int'(m_prog));
    chk(m_vld ? tag : "R8", "status_vld", int'(status_vld), int'(m_vld));
    if (m_vld) chk(tag, "status", int'(status), m_st);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ld_stb = 1'b0; dec_stb = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_cnt = 'h1FFFF; m_prog = 0; m_vld = 0; m_st = 0; tag = "R1";
    compare_all();
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic step(bit ld, int data, bit dec);
    ld_stb = ld; ld_data = 17'(data); dec_stb = dec;
    @(posedge clk);
    m_vld = ld || dec;
    if (ld) begin
      tag = dec ? "R7" : (m_prog ? "R3" : "R2");
      if (m_prog) m_st = 1;
      else begin m_st = 0; m_cnt = data & 'h1FFFF; m_prog = 1; end
    end else if (dec) begin
      if (!m_prog) begin m_st = 3; tag = "R6"; end
      else if (m_cnt == 0) begin m_st = 2; tag = "R5"; end
      else begin m_st = 0; m_cnt = m_cnt - 1; tag = "R4"; end
    end else begin
      tag = m_prog ? "R10" : "R9";
    end
    @(negedge clk);
    ld_stb = 1'b0; dec_stb = 1'b0;
    compare_all();
  endtask

  initial begin
    do_reset();
    step(0, 0, 1);
    step(0, 0, 0);
    step(1, 3, 1);
    step(1, 5, 0);
    step(1, 7, 1);
    step(0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    step(0, 0, 1);
    step(1, 9, 1);
    step(1, 9, 0);
    step(0, 0, 0);
    do_reset();
    step(1, 'h1FFFF, 0);
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 0);
    do_reset();
    step(1, 0, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    step(0, 0, 1);
    do_reset();
    step(1, 'h0A5C3, 0);
    for (int i = 0; i < 20; i++) step(0, 0, (i % 3) != 2);
    step(1, 1, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule